// File: doc/BRIEF.md
# Low-Randomness Masked AND Gate

This block multiplies two Boolean-masked bits of order D. Each operand arrives as D+1 shares, and the true value is the XOR of those shares. The output is a fresh (D+1)-share sharing of the product. Share-wise products stay in their own share domain. Cross products are absorbed into the output shares under fresh random bits. The random bits are reused in rotated form, so one random vector protects up to four cross terms per output share. The block needs about D(D+1)/4 random bits per multiplication, against D(D+1)/2 for a plain domain-separated gate.

The gate is built from parts:
- an inner-domain term a_i·b_i with no delay;
- floor(D/4) ordered five-stage chains;
- at most one tail block, chosen by D mod 4.

The operand shares travel through a tap line that is as deep as the longest part. Each part reads its products from the tap that matches its stage. Every output is aligned to one common latency, and a new operand pair can be accepted on every cycle.

Top module: `umand_gate`

## Requirements
- R1: For every input pair, the XOR of all q_o shares equals (XOR of the a_i shares) AND (XOR of the b_i shares) of the pair presented LAT cycles earlier, with a new pair accepted every cycle.
- R2: The latency LAT is 5 when D is 4 or more. For D = 3, 2 and 1 it is 4, 2 and 1 cycles.
- R3: While reset is held, and for the first LAT clock edges after its release, q_o is all zero.
- R4: The rnd_i port is 1, 2, 4, 5, 9, 14, 16 and 18 bits wide for D = 1 to 8. Chain k uses bits [k(D+1) +: D+1]. The tail uses the bits above all chains, starting at bit floor(D/4)(D+1).
- R5: With all operand shares zero, q_o equals the pure mask pattern formed by the formulas of R6 and R7 with every product term zero.
- R6: Let rot(v,n)[i] = v[(i+n) mod (D+1)]. Chain k uses s = 2k+1, t = 2k+2 and its random vector r. It adds r_i ^ a_i b_(i+s) ^ a_(i+s) b_i ^ r_(i+1) ^ a_i b_(i+t) ^ a_(i+t) b_i to share i, in this order, one register stage per term.
- R7: Let l = floor(D/4), s = 2l+1 and t = 2l+2. The tail depends on D mod 4:
  - D mod 4 = 3: share i gets the R6 chain without its last term (four stages).
  - D = 2: share i gets z_i ^ a_i b_(i+1) ^ a_(i+1) b_i, with z = (r0, r1, r0^r1).
  - D mod 4 = 2 and D > 2: share i gets r_i ^ a_i b_(i+s) ^ r_(i+t) ^ a_i b_(i+t).
  - D mod 4 = 1: share i gets r_(i mod (D+1)/2) ^ a_i b_(i+s).
  - D mod 4 = 0: there is no tail.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| a_i | input | D+1 | Shares of operand a |
| b_i | input | D+1 | Shares of operand b |
| rnd_i | input | RB | Fresh random bits, one full set per cycle |
| q_o | output | D+1 | Shares of a·b, LAT cycles after the operands |

## Verification
The assertions check three things on every cycle:
- the output shares recombine to the AND of the unmasked operands from LAT cycles earlier;
- each chain and each tail removes its own masks, so its output parity equals the parity of its cross products;
- the output stays quiet while the pipeline fills.

Parity cannot show a wrong rotation direction, a misplaced random field or a product term given to the wrong share. These faults only show in the bench's exact share-by-share comparison, run for D from 1 to 5. The zero-share runs expose the mask pattern alone, and an isolated single-product input measures the latency.

// File: rtl/umand_pkg.sv
package umand_pkg;

    typedef enum logic [2:0] {
        TAIL_NONE,
        TAIL_SINGLE,
        TAIL_SPLIT,
        TAIL_SHARED,
        TAIL_TRIPLE
    } tail_e;

    function automatic tail_e tail_kind(input int d);
        if (d % 4 == 0)      return TAIL_NONE;
        else if (d % 4 == 1) return TAIL_SINGLE;
        else if (d % 4 == 3) return TAIL_TRIPLE;
        else if (d == 2)     return TAIL_SHARED;
        else                 return TAIL_SPLIT;
    endfunction

    function automatic int tail_lat(input int d);
        if (d % 4 == 0)      return 0;
        else if (d % 4 == 3) return 4;
        else if (d == 2)     return 2;
        else                 return 1;
    endfunction

    function automatic int tail_bits(input int d);
        if (d % 4 == 0)      return 0;
        else if (d % 4 == 1) return (d + 1) / 2;
        else if (d == 2)     return 2;
        else                 return d + 1;
    endfunction

    function automatic int tail_taps(input int d);
        if (d % 4 == 3)      return 4;
        else if (d == 2)     return 2;
        else                 return 1;
    endfunction

    function automatic int gate_lat(input int d);
        return (d >= 4) ? 5 : tail_lat(d);
    endfunction

    function automatic int rand_bits(input int d);
        return (d / 4) * (d + 1) + tail_bits(d);
    endfunction

endpackage

// File: rtl/umand_taps.sv
module umand_taps #(
    parameter int W     = 8,
    parameter int DEPTH = 1
) (
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic [W-1:0]              din,
    output logic [DEPTH:0][W-1:0]     taps_o
);
    typedef struct packed {
        logic [DEPTH-1:0][W-1:0] line;
    } line_t;

    line_t line_d, line_q;

    always_comb begin
        line_d = line_q;
        line_d.line[0] = din;
        for (int j = 1; j < DEPTH; j++) begin
            line_d.line[j] = line_q.line[j-1];
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) line_q <= '0;
        else        line_q <= line_d;
    end

    always_comb begin
        taps_o[0] = din;
        for (int j = 0; j < DEPTH; j++) begin
            taps_o[j+1] = line_q.line[j];
        end
    end
endmodule

// File: rtl/umand_seq.sv
module umand_seq #(
    parameter int N      = 6,
    parameter int SOFS   = 1,
    parameter bit PSEUDO = 1'b0,
    localparam int STG   = PSEUDO ? 4 : 5
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic [STG-1:0][N-1:0]   a_t,
    input  logic [STG-1:0][N-1:0]   b_t,
    input  logic [N-1:0]            r_i,
    output logic [N-1:0]            q_o
);
    localparam int S1 = SOFS;
    localparam int S2 = SOFS + 1;

    function automatic logic [N-1:0] rotv(input logic [N-1:0] v, input int n);
        logic [N-1:0] res;
        for (int i = 0; i < N; i++) res[i] = v[(i + n) % N];
        return res;
    endfunction

    typedef struct packed {
        logic [STG-1:0][N-1:0] acc;
        logic [1:0][N-1:0]     rdly;
        logic [2:0]            fill;
    } seq_t;

    seq_t st_d, st_q;
    logic [STG-1:0][N-1:0] term;

    // each stage j reads the operand tap that is j cycles old
    for (genvar j = 0; j < STG; j++) begin : g_term
        if (j == 0) begin : g_t0
            assign term[j] = r_i ^ (a_t[j] & rotv(b_t[j], S1));
        end else if (j == 1) begin : g_t1
            assign term[j] = rotv(a_t[j], S1) & b_t[j];
        end else if (j == 2) begin : g_t2
            assign term[j] = rotv(st_q.rdly[1], 1);
        end else if (j == 3) begin : g_t3
            assign term[j] = a_t[j] & rotv(b_t[j], S2);
        end else begin : g_t4
            assign term[j] = rotv(a_t[j], S2) & b_t[j];
        end
    end

    always_comb begin
        st_d = st_q;
        st_d.rdly[0] = r_i;
        st_d.rdly[1] = st_q.rdly[0];
        st_d.acc[0]  = term[0];
        for (int j = 1; j < STG; j++) begin
            st_d.acc[j] = st_q.acc[j-1] ^ term[j];
        end
        if (st_q.fill != 3'(STG)) st_d.fill = st_q.fill + 3'd1;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign q_o = st_q.acc[STG-1];

    // parity of the cross products this chain absorbs, taken at entry
    logic xpar;
    always_comb begin
        xpar = (^(a_t[0] & rotv(b_t[0], S1))) ^ (^(rotv(a_t[0], S1) & b_t[0]))
             ^ (^(a_t[0] & rotv(b_t[0], S2)));
        if (!PSEUDO) xpar = xpar ^ (^(rotv(a_t[0], S2) & b_t[0]));
    end

    assert_chain_unmask_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q.fill == 3'(STG)) |-> ((^st_q.acc[STG-1]) == $past(xpar, STG)))
        else $error("chain masks do not cancel");
endmodule

// File: rtl/umand_tail.sv
module umand_tail import umand_pkg::*; #(
    parameter int N        = 6,
    parameter int D        = 5,
    localparam tail_e KIND = tail_kind(D),
    localparam int TB      = tail_bits(D),
    localparam int NT      = tail_taps(D)
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic [NT-1:0][N-1:0]   a_t,
    input  logic [NT-1:0][N-1:0]   b_t,
    input  logic [TB-1:0]          r_i,
    output logic [N-1:0]           q_o
);
    function automatic logic [N-1:0] rotv(input logic [N-1:0] v, input int n);
        logic [N-1:0] res;
        for (int i = 0; i < N; i++) res[i] = v[(i + n) % N];
        return res;
    endfunction

    if (KIND == TAIL_TRIPLE) begin : g_triple
        umand_seq #(.N(N), .SOFS(2 * (D / 4) + 1), .PSEUDO(1'b1)) u_seq (
            .clk(clk), .rst_n(rst_n), .a_t(a_t), .b_t(b_t), .r_i(r_i), .q_o(q_o)
        );
    end else if (KIND == TAIL_SINGLE) begin : g_single
        localparam int S1 = 2 * (D / 4) + 1;
        localparam int H  = N / 2;
        typedef struct packed { logic [N-1:0] acc; logic fill; } one_t;
        one_t st_d, st_q;
        logic [N-1:0] z;
        always_comb begin
            for (int i = 0; i < N; i++) z[i] = r_i[i % H];
            st_d      = st_q;
            st_d.acc  = z ^ (a_t[0] & rotv(b_t[0], S1));
            st_d.fill = 1'b1;
        end
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) st_q <= '0;
            else        st_q <= st_d;
        end
        assign q_o = st_q.acc;
        assert_tail_unmask_R7: assert property (@(posedge clk) disable iff (!rst_n)
            st_q.fill |-> ((^st_q.acc) == $past(^(a_t[0] & rotv(b_t[0], S1)), 1)))
            else $error("single tail masks do not cancel");
    end else if (KIND == TAIL_SPLIT) begin : g_split
        localparam int S1 = 2 * (D / 4) + 1;
        localparam int S2 = S1 + 1;
        typedef struct packed { logic [N-1:0] x; logic [N-1:0] y; logic fill; } two_t;
        two_t st_d, st_q;
        always_comb begin
            st_d      = st_q;
            st_d.x    = r_i ^ (a_t[0] & rotv(b_t[0], S1));
            st_d.y    = rotv(r_i, S2) ^ (a_t[0] & rotv(b_t[0], S2));
            st_d.fill = 1'b1;
        end
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) st_q <= '0;
            else        st_q <= st_d;
        end
        assign q_o = st_q.x ^ st_q.y;
        assert_split_unmask_R7: assert property (@(posedge clk) disable iff (!rst_n)
            st_q.fill |-> ((^q_o) == $past((^(a_t[0] & rotv(b_t[0], S1)))
                                          ^ (^(a_t[0] & rotv(b_t[0], S2))), 1)))
            else $error("split tail masks do not cancel");
    end else begin : g_shared
        typedef struct packed { logic [1:0][N-1:0] acc; logic [1:0] fill; } sh_t;
        sh_t st_d, st_q;
        logic [N-1:0] z;
        always_comb begin
            z = {r_i[0] ^ r_i[1], r_i[1], r_i[0]};
            st_d        = st_q;
            st_d.acc[0] = z ^ (a_t[0] & rotv(b_t[0], 1));
            st_d.acc[1] = st_q.acc[0] ^ (rotv(a_t[1], 1) & b_t[1]);
            if (st_q.fill != 2'd2) st_d.fill = st_q.fill + 2'd1;
        end
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) st_q <= '0;
            else        st_q <= st_d;
        end
        assign q_o = st_q.acc[1];
        assert_shared_unmask_R7: assert property (@(posedge clk) disable iff (!rst_n)
            (st_q.fill == 2'd2) |-> ((^st_q.acc[1]) == $past((^(a_t[0] & rotv(b_t[0], 1)))
                                                   ^ (^(rotv(a_t[0], 1) & b_t[0])), 2)))
            else $error("shared tail masks do not cancel");
    end
endmodule

// File: rtl/umand_gate.sv
module umand_gate import umand_pkg::*; #(
    parameter int D   = 5,
    localparam int N  = D + 1,
    localparam int RB = rand_bits(D)
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic [N-1:0]    a_i,
    input  logic [N-1:0]    b_i,
    input  logic [RB-1:0]   rnd_i,
    output logic [N-1:0]    q_o
);
    localparam int    LAT = gate_lat(D);
    localparam int    NC  = D / 4;
    localparam int    NCA = (NC > 0) ? NC : 1;
    localparam tail_e TK  = tail_kind(D);
    localparam int    TB  = tail_bits(D);
    localparam int    TL  = tail_lat(D);
    localparam int    NT  = tail_taps(D);

    logic [LAT:0][2*N-1:0] ab_t;
    logic [LAT:0][N-1:0]   a_t, b_t;
    logic [NCA-1:0][N-1:0] cpl_o;
    logic [N-1:0]          tail_al;

    umand_taps #(.W(2 * N), .DEPTH(LAT)) u_line (
        .clk(clk), .rst_n(rst_n), .din({b_i, a_i}), .taps_o(ab_t)
    );

    for (genvar j = 0; j <= LAT; j++) begin : g_split
        assign a_t[j] = ab_t[j][N-1:0];
        assign b_t[j] = ab_t[j][2*N-1:N];
    end

    if (NC == 0) begin : g_no_chain
        assign cpl_o[0] = '0;
    end else begin : g_chains
        for (genvar k = 0; k < NC; k++) begin : g_chain
            umand_seq #(.N(N), .SOFS(2 * k + 1), .PSEUDO(1'b0)) u_cpl (
                .clk(clk), .rst_n(rst_n),
                .a_t(a_t[4:0]), .b_t(b_t[4:0]),
                .r_i(rnd_i[k*N +: N]), .q_o(cpl_o[k])
            );
        end
    end

    if (TK == TAIL_NONE) begin : g_no_tail
        assign tail_al = '0;
    end else begin : g_tail
        logic [N-1:0] tail_raw;
        umand_tail #(.N(N), .D(D)) u_tail (
            .clk(clk), .rst_n(rst_n),
            .a_t(a_t[NT-1:0]), .b_t(b_t[NT-1:0]),
            .r_i(rnd_i[NC*N +: TB]), .q_o(tail_raw)
        );
        if (TL == LAT) begin : g_aligned
            assign tail_al = tail_raw;
        end else begin : g_align
            localparam int ALN = LAT - TL;
            typedef struct packed { logic [ALN-1:0][N-1:0] pipe; } aln_t;
            aln_t al_d, al_q;
            always_comb begin
                al_d = al_q;
                al_d.pipe[0] = tail_raw;
                for (int j = 1; j < ALN; j++) al_d.pipe[j] = al_q.pipe[j-1];
            end
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) al_q <= '0;
                else        al_q <= al_d;
            end
            assign tail_al = al_q.pipe[ALN-1];
        end
    end

    always_comb begin
        q_o = (a_t[LAT] & b_t[LAT]) ^ tail_al;
        for (int k = 0; k < NCA; k++) q_o = q_o ^ cpl_o[k];
    end

    // cycles since reset, saturating at LAT (used by the checks below)
    typedef struct packed { logic [2:0] fill; } top_t;
    top_t st_d, st_q;
    always_comb begin
        st_d = st_q;
        if (st_q.fill != 3'(LAT)) st_d.fill = st_q.fill + 3'd1;
    end
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assert_share_parity_R1: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q.fill == 3'(LAT)) |-> ((^q_o) == $past((^a_i) & (^b_i), LAT)))
        else $error("recombined output is not the AND of the inputs");

    assert_quiet_fill_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q.fill != 3'(LAT)) |-> (q_o == '0))
        else $error("output moved while the pipeline was filling");
endmodule

// File: tb/sim_umand_gate.sv
module umand_lane #(
    parameter int D = 1
) (
    input  logic clk,
    input  logic rst_n,
    output int   n_chk,
    output int   n_bad,
    output logic done
);
    localparam int N   = D + 1;
    localparam int LAT = (D >= 4) ? 5 : ((D == 3) ? 4 : ((D == 2) ? 2 : 1));

    function automatic int rb_table(input int d);
        case (d)
            1: return 1;   2: return 2;   3: return 4;   4: return 5;
            5: return 9;   6: return 14;  7: return 16;  default: return 18;
        endcase
    endfunction

    localparam int RB = rb_table(D);

    logic [N-1:0]  a, b, q;
    logic [RB-1:0] r;

    logic [N-1:0]  ha [64];
    logic [N-1:0]  hb [64];
    logic [RB-1:0] hr [64];
    string         ht [64];
    int            cnt;

    umand_gate #(.D(D)) u0 (.clk(clk), .rst_n(rst_n), .a_i(a), .b_i(b), .rnd_i(r), .q_o(q));

    function automatic logic [N-1:0] model(input logic [N-1:0] av, input logic [N-1:0] bv,
                                           input logic [RB-1:0] rv);
        logic [N-1:0] res;
        logic [63:0]  rw;
        int s, t, l, base, h;
        rw  = 64'(rv);
        res = av & bv;
        for (int k = 0; k < D / 4; k++) begin
            s = 2 * k + 1; t = 2 * k + 2; base = k * N;
            for (int i = 0; i < N; i++)
                res[i] = res[i] ^ rw[base + i] ^ (av[i] & bv[(i+s)%N]) ^ (av[(i+s)%N] & bv[i])
                       ^ rw[base + (i+1)%N] ^ (av[i] & bv[(i+t)%N]) ^ (av[(i+t)%N] & bv[i]);
        end
        l = D / 4; s = 2 * l + 1; t = 2 * l + 2; base = l * N; h = N / 2;
        for (int i = 0; i < N; i++) begin
            if (D % 4 == 3)
                res[i] = res[i] ^ rw[base + i] ^ (av[i] & bv[(i+s)%N]) ^ (av[(i+s)%N] & bv[i])
                       ^ rw[base + (i+1)%N] ^ (av[i] & bv[(i+t)%N]);
            else if (D == 2)
                res[i] = res[i] ^ ((i == 2) ? (rw[0] ^ rw[1]) : rw[i])
                       ^ (av[i] & bv[(i+1)%N]) ^ (av[(i+1)%N] & bv[i]);
            else if (D % 4 == 2)
                res[i] = res[i] ^ rw[base + i] ^ (av[i] & bv[(i+s)%N])
                       ^ rw[base + (i+t)%N] ^ (av[i] & bv[(i+t)%N]);
            else if (D % 4 == 1)
                res[i] = res[i] ^ rw[base + (i % h)] ^ (av[i] & bv[(i+s)%N]);
        end
        return res;
    endfunction

    task automatic chk(input bit ok, input string tag, input logic [31:0] got, input logic [31:0] exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL D=%0d %s got=%h exp=%h", D, tag, got, exp);
        end
    endtask

    task automatic step(input logic [N-1:0] av, input logic [N-1:0] bv,
                        input logic [RB-1:0] rv, input string tag);
        int idx;
        logic [N-1:0] e;
        a = av; b = bv; r = rv;
        ha[cnt % 64] = av; hb[cnt % 64] = bv; hr[cnt % 64] = rv; ht[cnt % 64] = tag;
        cnt++;
        @(negedge clk);
        idx = cnt - LAT;
        if (idx < 0) begin
            chk(q == '0, "R3 fill", 32'(q), 32'd0);
        end else begin
            e = model(ha[idx % 64], hb[idx % 64], hr[idx % 64]);
            chk(q == e, ht[idx % 64], 32'(q), 32'(e));
            chk((^q) == ((^ha[idx % 64]) & (^hb[idx % 64])), "R1 parity",
                32'(^q), 32'((^ha[idx % 64]) & (^hb[idx % 64])));
        end
    endtask

    initial begin
        n_chk = 0; n_bad = 0; done = 1'b0; cnt = 0;
        a = '0; b = '0; r = '0;
        void'($urandom(32'd1234 + D));
        @(negedge clk);
        chk(q == '0, "R3 reset", 32'(q), 32'd0);
        chk($bits(u0.rnd_i) == RB, "R4 width", 32'($bits(u0.rnd_i)), 32'(RB));
        wait (rst_n);
        // random streaming, back to back (R6 R7 share formulas)
        for (int n = 0; n < 300; n++)
            step(N'($urandom()), N'($urandom()), RB'($urandom()), "R6 R7 random");
        // zero shares: pure mask pattern (R5)
        for (int n = 0; n < 40; n++)
            step('0, '0, RB'($urandom()), "R5 masks");
        // all-ones shares
        for (int n = 0; n < 10; n++)
            step('1, '1, RB'($urandom()), "R1 ones");
        // latency: isolated single inner product (R2)
        for (int n = 0; n < LAT + 1; n++) step('0, '0, '0, "R2 idle");
        step(N'(1), N'(1), '0, "R2 impulse");
        for (int n = 0; n < LAT + 1; n++) step('0, '0, '0, "R2 after");
        // single cross term a0*b_last, no masks
        step(N'(1), N'(1) << (N - 1), '0, "R6 R7 cross");
        for (int n = 0; n < LAT; n++) step('0, '0, '0, "R6 R7 flush");
        done = 1'b1;
    end
endmodule

module sim_umand_gate;
    localparam int CLK_PERIOD = 10;
    localparam int WDOG       = 20000;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    int   chk_n [1:5];
    int   bad_n [1:5];
    logic [5:1] done;
    bit   timed_out = 1'b0;

    always #(CLK_PERIOD / 2) clk = ~clk;

    for (genvar d = 1; d <= 5; d++) begin : g_lane
        umand_lane #(.D(d)) lane (
            .clk(clk), .rst_n(rst_n), .n_chk(chk_n[d]), .n_bad(bad_n[d]), .done(done[d])
        );
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
    end

    initial begin
        int total, bad;
        fork
            wait (&done);
            begin
                repeat (WDOG) @(posedge clk);
                timed_out = 1'b1;
            end
        join_any
        total = 0; bad = 0;
        for (int d = 1; d <= 5; d++) begin
            total += chk_n[d];
            bad   += bad_n[d];
        end
        if (timed_out && !(&done)) begin
            total++; bad++;
            $display("FAIL watchdog: run did not finish, got=%b exp=%b", done, 5'b11111);
        end
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule